// File: doc/BRIEF.md
# SPI Frame Master

A master-side synchronous serial port that moves one data word per frame in each direction using the SPI frame format. A frame is started by handing a word across a valid/ready handshake. The port then pulls its active-low frame strobe low, toggles a serial clock derived from the system clock, and shifts the word out most significant bit first. At the same time it samples the receive line on the opposite clock edge. When the frame ends, the received word is presented right-aligned together with a one-cycle valid pulse.

Clock polarity, clock phase, word length (4 to 32 bits) and the clock divider are all taken from inputs. They are captured at the moment a word is accepted and held for the rest of the frame. In phase-1 mode the frame is padded with idle clock time at both ends. Between frames the transmit line keeps driving the last bit sent. Dropping the enable aborts any frame in progress and forces the transmit line low.

Top module: `spi_frame_master`

## Requirements
- R1: `frm_no` is high while no frame is running. It goes low in the cycle after a word is accepted and returns high in the cycle the frame ends.
- R2: Outside a frame, `sclk_o` follows `cpol_i` with one cycle of delay. Inside a frame it changes level only on a half-period boundary, and a half-period is `div_i`+1 system clock cycles.
- R3: With phase 0 (`cpha_i`=0), the first clock edge comes one half-period after the strobe falls. The frame has 2N clock edges for N bits, and the strobe rises one half-period after the last edge, so the frame lasts (2N+1)·(`div_i`+1) cycles.
- R4: With phase 1 (`cpha_i`=1), the first clock edge also comes one half-period after the strobe falls. The strobe rises one full clock period after the last edge, so the frame lasts (2N+2)·(`div_i`+1) cycles.
- R5: When polarity and phase are equal, `mosi_o` changes only on falling clock edges and `miso_i` is sampled on rising edges. When they differ, `mosi_o` changes on rising edges and `miso_i` is sampled on falling edges.
- R6: `len_i` encodes the word length minus one. Codes 3..31 give 4..32 bits, and codes 0..2 are treated as 4 bits. Bit N-1 of `tx_data_i` is on `mosi_o` from the cycle the strobe falls, and the remaining bits follow in descending order.
- R7: After a frame ends, `mosi_o` keeps driving the last bit sent (bit 0) until the next frame starts.
- R8: While `en_i` is low, `mosi_o` is low. A frame in progress is aborted: in the next cycle `frm_no` is high and `busy_o` is low, and no `rx_valid_o` pulse is produced.
- R9: `busy_o` is high from the cycle after acceptance until the cycle the strobe rises. In that same cycle `rx_valid_o` pulses for one cycle, and `rx_data_o` holds the N received bits right-aligned with zero upper bits.
- R10: `tx_ready_o` equals `en_i` and not `busy_o`. A word is accepted only on a cycle where `tx_valid_i` and `tx_ready_o` are both high, and `tx_valid_i` during a frame has no effect.
- R11: Changes to `cpol_i`, `cpha_i`, `len_i` and `div_i` during a frame do not change that frame's timing or data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Port enable; low aborts and forces mosi low |
| cpol_i | input | 1 | Serial clock idle level |
| cpha_i | input | 1 | Clock phase select |
| len_i | input | 5 | Word length minus one |
| div_i | input | 8 | Half-period minus one, in system cycles |
| tx_valid_i | input | 1 | Transmit word offered |
| tx_ready_o | output | 1 | Port can accept a word |
| tx_data_i | input | 32 | Transmit word, right-aligned |
| rx_valid_o | output | 1 | One-cycle pulse with received word |
| rx_data_o | output | 32 | Received word, right-aligned |
| busy_o | output | 1 | Frame in progress |
| sclk_o | output | 1 | Serial clock |
| frm_no | output | 1 | Frame strobe, active low |
| mosi_o | output | 1 | Serial transmit data |
| miso_i | input | 1 | Serial receive data |

## Verification
Frames are run for all four polarity/phase pairs and for lengths of 4, 8, 10, 12, 16 and 32 bits, as well as a clamped length code. Together these separate the edge-role rules, the phase padding and the MSB-first ordering at both ends of the length range. The divider settings 0 through 3 show whether the half-period scales correctly rather than merely existing. One frame has every configuration input changed and a second word offered while it runs, which exposes any configuration that is sampled live or any handshake that leaks through. An abort in mid-frame followed by a disabled interval tells apart a clean abort, a forced-low transmit line and the line returning to its held bit.

// File: rtl/spi_master_pkg.sv
package spi_master_pkg;
  localparam int unsigned MAX_W = 32;
  localparam int unsigned DIV_W = 8;
  localparam int unsigned LEN_W = $clog2(MAX_W);
  localparam int unsigned NB_W  = LEN_W + 1;
  localparam int unsigned K_W   = NB_W + 1;   // half-period index up to 2*MAX_W+2

  typedef struct packed {
    logic             cpol;
    logic             cpha;
    logic [NB_W-1:0]  nbits;
    logic [DIV_W-1:0] div;
  } frame_cfg_t;

  function automatic logic [NB_W-1:0] len_to_bits(input logic [LEN_W-1:0] len);
    if (len < LEN_W'(3)) return NB_W'(4);
    return NB_W'(len) + NB_W'(1);
  endfunction
endpackage

// File: rtl/spi_half_div.sv
module spi_half_div
  import spi_master_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;

  assign tick_o = run_i && (cnt_q == div_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (!run_i || tick_o) cnt_q <= '0;
    else                       cnt_q <= cnt_q + 1'b1;
  end

  // R2
  half_cnt_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> cnt_q <= div_i);
endmodule

// File: rtl/spi_frame_seq.sv
module spi_frame_seq
  import spi_master_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic       start_i,
  input  logic       cpol_live_i,
  input  logic       tick_i,
  input  frame_cfg_t cfg_i,
  output logic       busy_o,
  output logic       frm_no,
  output logic       sclk_o,
  output logic       sample_o,
  output logic       shift_o,
  output logic       done_o
);
  logic [K_W-1:0] k_q, k_nx, n2, end_k;
  logic           busy_q, frm_q, sclk_q, act, edge_w;

  assign n2     = {1'b0, cfg_i.nbits} << 1;
  assign end_k  = n2 + K_W'(1) + K_W'(cfg_i.cpha);
  assign k_nx   = k_q + 1'b1;
  assign act    = tick_i && en_i;
  assign edge_w = act && (k_nx <= n2);
  // sampling edges: odd half-periods in phase 0, even in phase 1
  assign sample_o = edge_w && (k_nx[0] != cfg_i.cpha);
  // no shift on the very first drive edge (phase 1) or after the last bit (phase 0)
  assign shift_o  = edge_w && !sample_o &&
                    (cfg_i.cpha ? (k_nx != K_W'(1)) : (k_nx != n2));
  assign done_o   = act && (k_nx == end_k);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      frm_q  <= 1'b1;
      sclk_q <= 1'b0;
      k_q    <= '0;
    end else if (!en_i) begin
      busy_q <= 1'b0;
      frm_q  <= 1'b1;
      sclk_q <= cpol_live_i;
      k_q    <= '0;
    end else if (!busy_q) begin
      sclk_q <= cpol_live_i;
      k_q    <= '0;
      if (start_i) begin
        busy_q <= 1'b1;
        frm_q  <= 1'b0;
      end
    end else if (act) begin
      k_q <= k_nx;
      if (edge_w) sclk_q <= ~sclk_q;
      if (done_o) begin
        busy_q <= 1'b0;
        frm_q  <= 1'b1;
      end
    end
  end

  assign busy_o = busy_q;
  assign frm_no = frm_q;
  assign sclk_o = sclk_q;

  // R1
  strobe_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_q |-> frm_q);
  // R2
  sclk_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && en_i && !tick_i |=> $stable(sclk_q));
  // R3
  tick_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> k_q < end_k);
  // R8
  abort_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !busy_q && frm_q);
endmodule

// File: rtl/spi_shift_unit.sv
module spi_shift_unit
  import spi_master_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [MAX_W-1:0] tx_data_i,
  input  logic [NB_W-1:0]  nbits_i,
  input  logic             shift_i,
  input  logic             sample_i,
  input  logic             miso_i,
  output logic             tx_bit_o,
  output logic [MAX_W-1:0] rx_word_o
);
  logic [MAX_W-1:0] tx_q, rx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_q <= '0;
      rx_q <= '0;
    end else if (load_i) begin
      tx_q <= tx_data_i << (NB_W'(MAX_W) - nbits_i);  // left-align word
      rx_q <= '0;
    end else begin
      if (shift_i)  tx_q <= tx_q << 1;
      if (sample_i) rx_q <= {rx_q[MAX_W-2:0], miso_i};
    end
  end

  assign tx_bit_o  = tx_q[MAX_W-1];
  assign rx_word_o = rx_q;

  // R5
  edge_role_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(shift_i && sample_i));
  // R7
  tx_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i && !shift_i |=> $stable(tx_q));
endmodule

// File: rtl/spi_frame_master.sv
module spi_frame_master
  import spi_master_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             cpol_i,
  input  logic             cpha_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic             tx_valid_i,
  output logic             tx_ready_o,
  input  logic [MAX_W-1:0] tx_data_i,
  output logic             rx_valid_o,
  output logic [MAX_W-1:0] rx_data_o,
  output logic             busy_o,
  output logic             sclk_o,
  output logic             frm_no,
  output logic             mosi_o,
  input  logic             miso_i
);
  frame_cfg_t       cfg_live, cfg_q;
  logic             start, tick, sample, shift, done, tx_bit, busy;
  logic [MAX_W-1:0] rx_word;
  logic             rx_valid_q;
  logic [MAX_W-1:0] rx_data_q;

  assign cfg_live   = '{cpol: cpol_i, cpha: cpha_i, nbits: len_to_bits(len_i), div: div_i};
  assign tx_ready_o = en_i && !busy;
  assign start      = tx_valid_i && tx_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cfg_q <= '0;
    else if (start) cfg_q <= cfg_live;
  end

  spi_half_div i_div (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_i (busy),
    .div_i (cfg_q.div),
    .tick_o(tick)
  );

  spi_frame_seq i_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (en_i),
    .start_i    (start),
    .cpol_live_i(cpol_i),
    .tick_i     (tick),
    .cfg_i      (cfg_q),
    .busy_o     (busy),
    .frm_no     (frm_no),
    .sclk_o     (sclk_o),
    .sample_o   (sample),
    .shift_o    (shift),
    .done_o     (done)
  );

  spi_shift_unit i_shift (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (start),
    .tx_data_i(tx_data_i),
    .nbits_i  (cfg_live.nbits),
    .shift_i  (shift),
    .sample_i (sample),
    .miso_i   (miso_i),
    .tx_bit_o (tx_bit),
    .rx_word_o(rx_word)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_valid_q <= 1'b0;
      rx_data_q  <= '0;
    end else begin
      rx_valid_q <= done;
      if (done) rx_data_q <= rx_word;
    end
  end

  assign rx_valid_o = rx_valid_q;
  assign rx_data_o  = rx_data_q;
  assign busy_o     = busy;
  assign mosi_o     = en_i && tx_bit;

  // R9
  rx_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |-> $rose(frm_no));
  // R9
  rx_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |=> !rx_valid_o);
  // R10
  accept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_i && tx_ready_o |=> busy_o && !frm_no);
endmodule

// File: tb/test_spi_frame_master.sv
module test_spi_frame_master;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        en = 1'b0, cpol = 1'b0, cpha = 1'b0, tx_valid = 1'b0, miso = 1'b0;
  logic [4:0]  len = '0;
  logic [7:0]  div = '0;
  logic [31:0] tx_data = '0;
  logic        tx_ready, rx_valid, busy, sclk, frm_n, mosi;
  logic [31:0] rx_data;

  int n_chk = 0, n_err = 0, cyc = 0;

  always #4 clk = ~clk;

  spi_frame_master i_spi_frame_master (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .cpol_i(cpol), .cpha_i(cpha),
    .len_i(len), .div_i(div), .tx_valid_i(tx_valid), .tx_ready_o(tx_ready),
    .tx_data_i(tx_data), .rx_valid_o(rx_valid), .rx_data_o(rx_data),
    .busy_o(busy), .sclk_o(sclk), .frm_no(frm_n), .mosi_o(mosi), .miso_i(miso)
  );

  // expected frame parameters set by the stimulus tasks
  int e_n = 4, e_cpha = 0, e_cpol = 0, e_div = 0;
  logic [31:0] e_slv = '0;
  bit e_mess = 0;

  // behavioural reference model
  bit m_busy = 0, m_frm = 1, m_sclk = 0, m_rxv = 0;
  int m_cnt = 0, m_k = 0, m_n = 4, m_div = 0, m_cpha = 0, m_bit = 0, m_ns = 0;
  logic [31:0] m_word = '0, m_acc = '0, m_rxd = '0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy = 0; m_frm = 1; m_sclk = 0; m_rxv = 0; m_rxd = '0;
      m_word = '0; m_bit = 0; m_ns = 0;
    end else begin
      m_rxv = 0;
      if (!en) begin
        m_busy = 0; m_frm = 1; m_sclk = cpol;
      end else if (!m_busy) begin
        m_sclk = cpol;
        if (tx_valid) begin
          m_busy = 1; m_frm = 0;
          m_n = (len < 3) ? 4 : int'(len) + 1;
          m_div = int'(div); m_cpha = int'(cpha);
          m_word = tx_data; m_bit = m_n - 1;
          m_cnt = 0; m_k = 0; m_acc = '0; m_ns = 0;
        end
      end else if (m_cnt == m_div) begin
        m_cnt = 0; m_k++;
        if (m_k <= 2 * m_n) begin
          m_sclk = !m_sclk;
          if (((m_k % 2) == 1) == (m_cpha == 0)) begin
            m_acc = {m_acc[30:0], miso}; m_ns++;
          end else if (!(m_cpha == 1 ? m_k == 1 : m_k == 2 * m_n)) begin
            m_bit--;
          end
        end
        if (m_k == 2 * m_n + 1 + m_cpha) begin
          m_busy = 0; m_frm = 1; m_rxv = 1; m_rxd = m_acc;
        end
      end else begin
        m_cnt++;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s at cycle %0d: actual %h expected %h", tag, cyc, act, exp);
    end
  endtask

  // independent per-frame counters
  int busy_cnt = 0, tog = 0;
  bit prev_busy = 0, prev_sclk = 0, prev_mosi = 0;

  always @(negedge clk) begin
    logic exp_mosi;
    cyc++;
    exp_mosi = en ? m_word[m_bit] : 1'b0;
    chk(frm_n == m_frm,     "R1 frame strobe", 32'(frm_n), 32'(m_frm));
    chk(sclk == m_sclk,     "R2 serial clock", 32'(sclk), 32'(m_sclk));
    chk(busy == m_busy,     "R9 busy", 32'(busy), 32'(m_busy));
    chk(rx_valid == m_rxv,  "R9 rx valid", 32'(rx_valid), 32'(m_rxv));
    chk(mosi == exp_mosi,   "R6/R7/R8 mosi", 32'(mosi), 32'(exp_mosi));
    chk(tx_ready == (en && !m_busy), "R10 tx ready", 32'(tx_ready), 32'(en && !m_busy));
    if (m_rxv) chk(rx_data == m_rxd, "R9 rx data model", rx_data, m_rxd);
    // R5: during a frame mosi moves only on the driving edge
    if (busy && prev_busy && en && mosi != prev_mosi)
      chk(sclk != prev_sclk && sclk == 1'(e_cpol ^ e_cpha), "R5 drive edge",
          32'(sclk), 32'(e_cpol ^ e_cpha));
    if (busy && !prev_busy) begin busy_cnt = 0; tog = 0; end
    if (busy) begin
      busy_cnt++;
      if (prev_busy && sclk != prev_sclk) tog++;
    end
    if (rx_valid) begin
      logic [63:0] mask;
      mask = (64'd1 << e_n) - 64'd1;
      chk(busy_cnt == (2 * e_n + 1 + e_cpha) * (e_div + 1),
          e_mess ? "R11 frame length" : (e_cpha != 0 ? "R4 frame length" : "R3 frame length"),
          32'(busy_cnt), 32'((2 * e_n + 1 + e_cpha) * (e_div + 1)));
      chk(tog == 2 * e_n, "R3/R4 edge count", 32'(tog), 32'(2 * e_n));
      chk(rx_data == (e_slv & mask[31:0]), e_mess ? "R11 rx word" : "R6 rx word",
          rx_data, e_slv & mask[31:0]);
    end
    prev_busy = busy; prev_sclk = sclk; prev_mosi = mosi;
    miso = (m_busy && m_ns < m_n) ? e_slv[m_n - 1 - m_ns] : 1'b0;
    if (cyc > 100000) begin
      n_err++;
      $display("FAIL watchdog expired at cycle %0d: actual hung expected done", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
      $finish;
    end
  end

  task automatic send(input bit cp, input bit ph, input logic [4:0] ln, input logic [7:0] dv,
                      input logic [31:0] d, input logic [31:0] s, input bit mess);
    @(negedge clk);
    cpol = cp; cpha = ph; len = ln; div = dv; tx_data = d; tx_valid = 1'b1;
    e_cpol = cp; e_cpha = ph; e_div = dv; e_n = (ln < 3) ? 4 : int'(ln) + 1;
    e_slv = s; e_mess = mess;
    @(negedge clk);
    if (mess) begin
      // R10/R11: keep offering a word and disturb every configuration input
      cpol = !cp; cpha = !ph; len = ln ^ 5'h5; div = dv + 8'd3; tx_data = ~d;
    end else begin
      tx_valid = 1'b0;
    end
    while (busy) @(negedge clk);
    tx_valid = 1'b0;
    cpol = cp; cpha = ph;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // reset state
    chk(frm_n == 1'b1 && busy == 1'b0 && rx_valid == 1'b0 && mosi == 1'b0,
        "R1 reset state", {frm_n, busy, rx_valid, mosi}, 32'h8);
    rst_n = 1'b1;
    @(negedge clk);
    en = 1'b1;
    repeat (2) @(negedge clk);
    send(1'b0, 1'b0, 5'd7,  8'd0, 32'h0000_00A5, 32'h0000_003C, 0);
    send(1'b1, 1'b1, 5'd15, 8'd2, 32'h0000_C3A1, 32'h0000_5E71, 0);
    send(1'b0, 1'b1, 5'd3,  8'd1, 32'h0000_0009, 32'h0000_0006, 0);
    send(1'b1, 1'b0, 5'd31, 8'd0, 32'h8F0F_3C01, 32'hDEAD_BEEF, 0);
    send(1'b0, 1'b0, 5'd1,  8'd1, 32'hFFFF_FFFA, 32'hFFFF_FFF5, 0);
    send(1'b1, 1'b0, 5'd11, 8'd3, 32'h0000_0B2D, 32'h0000_01E4, 1);
    send(1'b0, 1'b1, 5'd9,  8'd0, 32'h0000_02AB, 32'h0000_0155, 0);
    // R8: abort mid-frame
    @(negedge clk);
    cpol = 1'b1; cpha = 1'b0; len = 5'd15; div = 8'd1; tx_data = 32'h0000_A5C3; tx_valid = 1'b1;
    @(negedge clk);
    tx_valid = 1'b0;
    repeat (9) @(negedge clk);
    en = 1'b0;
    repeat (5) @(negedge clk);
    chk(frm_n == 1'b1 && busy == 1'b0 && mosi == 1'b0, "R8 after abort",
        {frm_n, busy, mosi}, 32'h4);
    en = 1'b1;
    repeat (3) @(negedge clk);
    send(1'b0, 1'b0, 5'd7, 8'd2, 32'h0000_0081, 32'h0000_00C3, 0);
    // R7: line holds bit 0 of last word while idle
    repeat (6) @(negedge clk);
    chk(mosi == 1'b1, "R7 idle hold", 32'(mosi), 32'h1);
    en = 1'b0;
    @(negedge clk);
    chk(mosi == 1'b0, "R8 disabled mosi", 32'(mosi), 32'h0);
    en = 1'b1;
    repeat (3) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
    $finish;
  end
endmodule